// File: doc/BRIEF.md
# Dual-Bank Shared Configuration Store with Per-Thread Selectors

This block holds the configuration words that steer a multi-threaded engine. It has two shared banks of 32-bit words that every thread can reach. Each thread also owns a private bank of 16-bit entries. Bit 0 of one private entry picks which shared bank that thread sees. Because of this, one thread can program the idle bank while the others keep running from the live one, and the banks swap when the thread flips its selector.

Each thread presents one 32-bit instruction word with a valid flag. Private 16-bit writes complete at once for every thread in parallel. Every operation on a shared bank goes through a single round-robin path that accepts at most one operation per cycle. These shared-bank operations are:

- writes of a register value into the configuration store, 32 or 128 bits wide;
- reads of one configuration word back into a register;
- an in-place masked update of one byte.

The block reads source registers from an external register file through a four-word read port. It returns read results through a one-word write port. Two combinational read ports expose the shared banks and the private banks.

Top module: `cfg_bank_unit`

## Requirements
- R1: After reset, every shared word in both banks and every private entry reads zero, and the register write strobe is low.
- R2: Opcode 0xB2 writes bits [15:0] into private entry bits [23:16] (modulo the private depth) of the issuing thread only. It is accepted in the cycle it is presented, all threads may do so in the same cycle, and the new value is readable after the next clock edge.
- R3: A shared-bank operation uses the bank named by bit 0 of private entry STATE_IDX (default 0) of the issuing thread.
- R4: Opcode 0xB0 with bit [15]=0 copies register bits [21:16] of the issuing thread into word bits [10:0] (modulo the bank depth) of the active bank. The result is visible on the config read port after the accepting edge.
- R5: Opcode 0xB0 with bit [15]=1 clears the two low bits of both the register index and the word index, then copies registers base..base+3 into words base..base+3.
- R6: A write or byte update to a word index at or above GLOBAL_BASE (default 48) lands in both banks.
- R7: Opcode 0xB1 reads word bits [10:0] of the active bank into register bits [21:16]. The register write strobe carries thread, index and data for exactly one cycle, the cycle after acceptance, so the value is usable no earlier than two cycles after issue.
- R8: Opcodes 0xB3..0xB6 update byte lane (opcode − 0xB3) of word bits [7:0], with mask bits [23:16] and data bits [15:8]. The new byte is (data & mask) | (old & ~mask), and the other three bytes are kept.
- R9: An 0xB0 write covering word RESET_EN_IDX (default 40) zeroes every word below GLOBAL_BASE in that bank, including words written by the same instruction. A byte update to that index does not clear anything, and the other bank is untouched.
- R10: At most one shared-bank operation is accepted per cycle, and competing threads are served round-robin, starting after the last thread served.
- R11: Any other opcode is accepted in the cycle it is presented and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | NT | Per-thread instruction valid |
| instr_word | input | NT*32 | Per-thread instruction words, thread t at bits [32t+31:32t] |
| instr_ready | output | NT | Instruction of thread t accepted this cycle |
| gpr_rd_thread | output | TW | Thread whose registers are read |
| gpr_rd_quad | output | 4 | Four-register group index being read |
| gpr_rd_data | input | 128 | Registers 4q..4q+3, register 4q+k at bits [32k+31:32k] |
| gpr_wr_en | output | 1 | Register write strobe for a read result |
| gpr_wr_thread | output | TW | Thread of the register write |
| gpr_wr_idx | output | 6 | Register index of the write |
| gpr_wr_data | output | 32 | Data written |
| cfg_rd_bank | input | 1 | Shared bank for the config read port |
| cfg_rd_idx | input | CAW | Word index for the config read port |
| cfg_rd_data | output | 32 | Shared word contents |
| pvt_rd_thread | input | TW | Thread for the private read port |
| pvt_rd_idx | input | PAW | Private entry index |
| pvt_rd_data | output | 16 | Private entry contents |

## Verification
A wrong bank selector or a stray global-write decode corrupts a word. That word shows up as a wrong value on the config read port right after the offending edge, and the bench reads it back before the next instruction. A clear that fires too widely, or fails to fire, shows as a wrong value in a word outside the target region on the very next read. A drifting arbiter pointer shows as the wrong thread order on the register write strobe, one cycle after each grant.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;
   localparam logic [7:0] OP_WRITE = 8'hB0;
   localparam logic [7:0] OP_READ  = 8'hB1;
   localparam logic [7:0] OP_SET16 = 8'hB2;
   localparam logic [7:0] OP_BYTE0 = 8'hB3;
   localparam logic [7:0] OP_BYTE3 = 8'hB6;

   typedef struct packed {
      logic       is_wr;
      logic       is_rd;
      logic       is_byte;
      logic       is_set;
      logic       wide;
      logic [1:0] lane;
   } op_dec_t;

   function automatic op_dec_t op_decode(input logic [31:0] w);
      op_dec_t d;
      logic [7:0] lane_full;
      d.is_wr   = (w[31:24] == OP_WRITE);
      d.is_rd   = (w[31:24] == OP_READ);
      d.is_set  = (w[31:24] == OP_SET16);
      d.is_byte = (w[31:24] >= OP_BYTE0) && (w[31:24] <= OP_BYTE3);
      d.wide    = w[15];
      lane_full = w[31:24] - OP_BYTE0;
      d.lane    = lane_full[1:0];
      return d;
   endfunction
endpackage

// File: rtl/cfgu_rr_arb.sv
module cfgu_rr_arb #(
   parameter int N = 3,
   localparam int W = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic [W-1:0] gnt_idx
);
   generate
      if (N < 2) begin : g_bad_n
         $error("cfgu_rr_arb needs at least two requesters");
      end
   endgenerate

   logic [W-1:0] ptr;
   logic         found;

   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      found   = 1'b0;
      for (int k = 0; k < N; k++) begin
         int c;
         c = (int'(ptr) + k) % N;
         if (!found && req[c]) begin
            gnt[c]  = 1'b1;
            gnt_idx = W'(c);
            found   = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else if (found) ptr <= W'((int'(gnt_idx) + 1) % N);
   end

   // R10
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
   // R10
   gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
endmodule

// File: rtl/cfgu_thread_store.sv
module cfgu_thread_store #(
   parameter int NT        = 3,
   parameter int PDEPTH    = 16,
   parameter int STATE_IDX = 0,
   localparam int TW  = $clog2(NT),
   localparam int PAW = $clog2(PDEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NT-1:0]     we,
   input  logic [NT*PAW-1:0] widx,
   input  logic [NT*16-1:0]  wdata,
   output logic [NT-1:0]     state_bit,
   input  logic [TW-1:0]     rd_thread,
   input  logic [PAW-1:0]    rd_idx,
   output logic [15:0]       rd_data
);
   generate
      if (STATE_IDX >= PDEPTH || PAW > 8) begin : g_bad_cfg
         $error("cfgu_thread_store: bad private bank parameters");
      end
   endgenerate

   logic [NT-1:0][PDEPTH-1:0][15:0] pvt;

   generate
      for (genvar t = 0; t < NT; t++) begin : g_thr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pvt[t] <= '0;
            else if (we[t]) pvt[t][widx[t*PAW +: PAW]] <= wdata[t*16 +: 16];
         end
         assign state_bit[t] = pvt[t][STATE_IDX][0];

         // R2
         pvt_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !we[t] |=> $stable(pvt[t]));
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int t = 0; t < NT; t++)
         if (rd_thread == TW'(t)) rd_data = pvt[t][rd_idx];
   end
endmodule

// File: rtl/cfgu_shared_store.sv
module cfgu_shared_store #(
   parameter int DEPTH        = 64,
   parameter int GLOBAL_BASE  = 48,
   parameter int RESET_EN_IDX = 40,
   localparam int CAW = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic           byte_en,
   input  logic           bank,
   input  logic [CAW-1:0] idx,
   input  logic           wide,
   input  logic [127:0]   wdata,
   input  logic [1:0]     lane,
   input  logic [7:0]     mask,
   input  logic [7:0]     bdata,
   output logic [31:0]    op_rdata,
   input  logic           rd_bank,
   input  logic [CAW-1:0] rd_idx,
   output logic [31:0]    rd_data
);
   generate
      if (GLOBAL_BASE % 4 != 0 || GLOBAL_BASE > DEPTH || RESET_EN_IDX >= GLOBAL_BASE || CAW > 11)
      begin : g_bad_cfg
         $error("cfgu_shared_store: bad bank parameters");
      end
   endgenerate

   logic [31:0] mem [2][DEPTH];
   logic [31:0] byte_word;
   logic [7:0]  old_b;
   logic [CAW-1:0] base;
   logic        clr_hit;

   assign op_rdata = mem[bank][idx];
   assign rd_data  = mem[rd_bank][rd_idx];
   assign base     = wide ? {idx[CAW-1:2], 2'b00} : idx;
   assign clr_hit  = wide ? (idx[CAW-1:2] == RESET_EN_IDX[CAW-1:2])
                          : (idx == CAW'(RESET_EN_IDX));

   always_comb begin
      old_b     = op_rdata[lane*8 +: 8];
      byte_word = op_rdata;
      byte_word[lane*8 +: 8] = (bdata & mask) | (old_b & ~mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++)
            for (int i = 0; i < DEPTH; i++) mem[b][i] <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < 4; k++) begin
            if (wide || k == 0) begin
               mem[bank][base + CAW'(k)] <= wdata[k*32 +: 32];
               if (int'(base) + k >= GLOBAL_BASE)
                  mem[!bank][base + CAW'(k)] <= wdata[k*32 +: 32];
            end
         end
         if (clr_hit)
            for (int j = 0; j < GLOBAL_BASE; j++) mem[bank][j] <= '0;
      end else if (byte_en) begin
         mem[bank][idx] <= byte_word;
         if (int'(idx) >= GLOBAL_BASE) mem[!bank][idx] <= byte_word;
      end
   end

   // checker state for the assertions below
   logic           glob_v, clr_v, clr_bank;
   logic [CAW-1:0] glob_idx;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_v <= 1'b0; clr_v <= 1'b0; clr_bank <= 1'b0; glob_idx <= '0;
      end else begin
         glob_v   <= (wr_en || byte_en) && int'(base) >= GLOBAL_BASE;
         glob_idx <= base;
         clr_v    <= wr_en && clr_hit;
         clr_bank <= bank;
      end
   end

   // R6
   global_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      glob_v |-> mem[0][glob_idx] == mem[1][glob_idx]);
   // R9
   reset_en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_v |-> mem[clr_bank][RESET_EN_IDX] == 32'h0);
endmodule

// File: rtl/cfg_bank_unit.sv
module cfg_bank_unit #(
   parameter int NT           = 3,
   parameter int DEPTH        = 64,
   parameter int PDEPTH       = 16,
   parameter int GLOBAL_BASE  = 48,
   parameter int RESET_EN_IDX = 40,
   parameter int STATE_IDX    = 0,
   localparam int TW  = $clog2(NT),
   localparam int CAW = $clog2(DEPTH),
   localparam int PAW = $clog2(PDEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NT-1:0]     instr_valid,
   input  logic [NT*32-1:0]  instr_word,
   output logic [NT-1:0]     instr_ready,
   output logic [TW-1:0]     gpr_rd_thread,
   output logic [3:0]        gpr_rd_quad,
   input  logic [127:0]      gpr_rd_data,
   output logic              gpr_wr_en,
   output logic [TW-1:0]     gpr_wr_thread,
   output logic [5:0]        gpr_wr_idx,
   output logic [31:0]       gpr_wr_data,
   input  logic              cfg_rd_bank,
   input  logic [CAW-1:0]    cfg_rd_idx,
   output logic [31:0]       cfg_rd_data,
   input  logic [TW-1:0]     pvt_rd_thread,
   input  logic [PAW-1:0]    pvt_rd_idx,
   output logic [15:0]       pvt_rd_data
);
   import cfgu_pkg::*;

   op_dec_t         dec [NT];
   logic [NT-1:0]   shared_req, gnt, set_we, state_bit;
   logic [NT*PAW-1:0] set_idx;
   logic [NT*16-1:0]  set_data;
   logic [TW-1:0]   gnt_idx;
   logic [31:0]     sel_word, sel_reg, op_rdata;
   op_dec_t         sel_dec;
   logic            any_gnt, rd_go, wr_go, byte_go;
   logic [10:0]     wide_idx;
   logic [127:0]    wdata;

   always_comb begin
      for (int t = 0; t < NT; t++) begin
         dec[t]        = op_decode(instr_word[t*32 +: 32]);
         shared_req[t] = instr_valid[t] && (dec[t].is_wr || dec[t].is_rd || dec[t].is_byte);
         set_we[t]     = instr_valid[t] && dec[t].is_set;
         set_idx[t*PAW +: PAW] = instr_word[t*32+16 +: PAW];
         set_data[t*16 +: 16]  = instr_word[t*32 +: 16];
         instr_ready[t] = instr_valid[t] && (gnt[t] || !shared_req[t]);
      end
   end

   cfgu_rr_arb #(.N(NT)) i_arb (
      .clk(clk), .rst_n(rst_n), .req(shared_req), .gnt(gnt), .gnt_idx(gnt_idx));

   cfgu_thread_store #(.NT(NT), .PDEPTH(PDEPTH), .STATE_IDX(STATE_IDX)) i_thr (
      .clk(clk), .rst_n(rst_n), .we(set_we), .widx(set_idx), .wdata(set_data),
      .state_bit(state_bit), .rd_thread(pvt_rd_thread), .rd_idx(pvt_rd_idx),
      .rd_data(pvt_rd_data));

   assign any_gnt  = |gnt;
   assign sel_word = instr_word[gnt_idx*32 +: 32];
   assign sel_dec  = op_decode(sel_word);
   assign wr_go    = any_gnt && sel_dec.is_wr;
   assign rd_go    = any_gnt && sel_dec.is_rd;
   assign byte_go  = any_gnt && sel_dec.is_byte;
   assign wide_idx = sel_dec.is_byte ? {3'b000, sel_word[7:0]} : sel_word[10:0];

   assign gpr_rd_thread = gnt_idx;
   assign gpr_rd_quad   = sel_word[21:18];
   assign sel_reg       = gpr_rd_data[sel_word[17:16]*32 +: 32];
   assign wdata         = sel_dec.wide ? gpr_rd_data : {96'h0, sel_reg};

   cfgu_shared_store #(.DEPTH(DEPTH), .GLOBAL_BASE(GLOBAL_BASE),
                       .RESET_EN_IDX(RESET_EN_IDX)) i_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .byte_en(byte_go),
      .bank(state_bit[gnt_idx]), .idx(wide_idx[CAW-1:0]), .wide(sel_dec.wide),
      .wdata(wdata), .lane(sel_dec.lane), .mask(sel_word[23:16]),
      .bdata(sel_word[15:8]), .op_rdata(op_rdata), .rd_bank(cfg_rd_bank),
      .rd_idx(cfg_rd_idx), .rd_data(cfg_rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gpr_wr_en     <= 1'b0;
         gpr_wr_thread <= '0;
         gpr_wr_idx    <= '0;
         gpr_wr_data   <= '0;
      end else begin
         gpr_wr_en     <= rd_go;
         gpr_wr_thread <= gnt_idx;
         gpr_wr_idx    <= sel_word[21:16];
         gpr_wr_data   <= op_rdata;
      end
   end

   // R7
   rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_go |=> gpr_wr_en);
   // R7
   rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_go |=> !gpr_wr_en);
   // R10
   one_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(instr_ready & shared_req) <= 1);
endmodule

// File: tb/test_cfg_bank_unit.sv
`timescale 1ns/1ps
module test_cfg_bank_unit;
   logic         clk = 0, rst_n = 0;
   logic [2:0]   vld = '0;
   logic [95:0]  wbus = '0;
   logic [2:0]   rdy;
   logic [1:0]   gpr_rd_thread, gpr_wr_thread;
   logic [3:0]   gpr_rd_quad;
   logic [127:0] gpr_rd_data;
   logic         gpr_wr_en;
   logic [5:0]   gpr_wr_idx;
   logic [31:0]  gpr_wr_data, cfg_rd_data;
   logic         cfg_rd_bank = 0;
   logic [5:0]   cfg_rd_idx = '0;
   logic [1:0]   pvt_rd_thread = '0;
   logic [3:0]   pvt_rd_idx = '0;
   logic [15:0]  pvt_rd_data;
   logic [31:0]  gpr [4][64];
   int checks = 0, fails = 0;
   bit done = 0, mon_on = 0;
   int seq [8];
   int nseq = 0;

   always #2.5 clk = ~clk;

   cfg_bank_unit i_cfg_bank_unit (
      .clk(clk), .rst_n(rst_n), .instr_valid(vld), .instr_word(wbus), .instr_ready(rdy),
      .gpr_rd_thread(gpr_rd_thread), .gpr_rd_quad(gpr_rd_quad), .gpr_rd_data(gpr_rd_data),
      .gpr_wr_en(gpr_wr_en), .gpr_wr_thread(gpr_wr_thread), .gpr_wr_idx(gpr_wr_idx),
      .gpr_wr_data(gpr_wr_data), .cfg_rd_bank(cfg_rd_bank), .cfg_rd_idx(cfg_rd_idx),
      .cfg_rd_data(cfg_rd_data), .pvt_rd_thread(pvt_rd_thread), .pvt_rd_idx(pvt_rd_idx),
      .pvt_rd_data(pvt_rd_data));

   always_comb
      for (int k = 0; k < 4; k++)
         gpr_rd_data[k*32 +: 32] = gpr[gpr_rd_thread][{gpr_rd_quad, 2'(k)}];

   always @(posedge clk) if (gpr_wr_en) gpr[gpr_wr_thread][gpr_wr_idx] <= gpr_wr_data;
   always @(negedge clk) if (mon_on && gpr_wr_en && nseq < 8) begin
      seq[nseq] = int'(gpr_wr_thread); nseq++;
   end

   function automatic logic [31:0] e_wr(input int g, input bit w, input int i);
      return {8'hB0, 2'b00, 6'(g), w, 4'h0, 11'(i)};
   endfunction
   function automatic logic [31:0] e_rd(input int g, input int i);
      return {8'hB1, 2'b00, 6'(g), 5'h0, 11'(i)};
   endfunction
   function automatic logic [31:0] e_byte(input int ln, input logic [7:0] m, input logic [7:0] d, input int i);
      return {8'hB3 + 8'(ln), m, d, 8'(i)};
   endfunction
   function automatic logic [31:0] e_set(input int e, input logic [15:0] v);
      return {8'hB2, 8'(e), v};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk_cfg(input bit b, input int i, input logic [31:0] exp, input string req);
      cfg_rd_bank = b; cfg_rd_idx = 6'(i); #0.2;
      chk(cfg_rd_data === exp, req, cfg_rd_data, exp);
   endtask

   task automatic chk_pvt(input int t, input int e, input logic [15:0] exp, input string req);
      pvt_rd_thread = 2'(t); pvt_rd_idx = 4'(e); #0.2;
      chk(pvt_rd_data === exp, req, {16'h0, pvt_rd_data}, {16'h0, exp});
   endtask

   // drives at a falling edge, holds until accepted, returns at the falling edge after acceptance
   task automatic issue(input int t, input logic [31:0] w);
      @(negedge clk);
      vld[t] = 1'b1; wbus[t*32 +: 32] = w; #1;
      while (!rdy[t]) begin @(negedge clk); #1; end
      @(negedge clk);
      vld[t] = 1'b0;
   endtask

   task automatic t_reset();
      // R1
      chk_cfg(0, 0, 0, "R1"); chk_cfg(1, 63, 0, "R1"); chk_cfg(0, 40, 0, "R1");
      chk_pvt(2, 0, 0, "R1");
      chk(gpr_wr_en === 1'b0, "R1", {31'h0, gpr_wr_en}, 0);
   endtask

   task automatic t_set16();
      // R2: three threads in the same cycle
      fork
         issue(0, e_set(3, 16'h1111));
         issue(1, e_set(3, 16'h2222));
         issue(2, e_set(19, 16'h3333));
      join
      chk_pvt(0, 3, 16'h1111, "R2"); chk_pvt(1, 3, 16'h2222, "R2");
      chk_pvt(2, 3, 16'h3333, "R2"); chk_pvt(0, 4, 16'h0, "R2");
   endtask

   task automatic t_wr32();
      gpr[0][5] = 32'h12345678;
      issue(0, e_wr(5, 0, 10));
      // R4
      chk_cfg(0, 10, 32'h12345678, "R4"); chk_cfg(1, 10, 0, "R4");
   endtask

   task automatic t_bank_sel();
      gpr[1][7] = 32'hCAFEF00D;
      issue(1, e_set(0, 16'h0001));
      issue(1, e_wr(7, 0, 10));
      // R3
      chk_cfg(1, 10, 32'hCAFEF00D, "R3"); chk_cfg(0, 10, 32'h12345678, "R3");
   endtask

   task automatic t_wr128();
      for (int k = 0; k < 4; k++) gpr[0][8+k] = 32'hA0A0_0000 + 32'(k);
      issue(0, e_wr(9, 1, 22));
      // R5
      for (int k = 0; k < 4; k++) chk_cfg(0, 20 + k, 32'hA0A0_0000 + 32'(k), "R5");
      chk_cfg(0, 19, 0, "R5"); chk_cfg(0, 24, 0, "R5");
   endtask

   task automatic t_global();
      gpr[0][12] = 32'h0BADBEEF;
      issue(0, e_wr(12, 0, 50));
      // R6
      chk_cfg(0, 50, 32'h0BADBEEF, "R6"); chk_cfg(1, 50, 32'h0BADBEEF, "R6");
      issue(1, e_byte(2, 8'hFF, 8'h5A, 52));
      chk_cfg(0, 52, 32'h005A0000, "R6"); chk_cfg(1, 52, 32'h005A0000, "R6");
   endtask

   task automatic t_rdcfg();
      issue(1, e_rd(20, 10));
      // R7: strobe in the cycle after acceptance
      chk(gpr_wr_en === 1'b1, "R7", {31'h0, gpr_wr_en}, 1);
      chk(gpr_wr_thread === 2'd1 && gpr_wr_idx === 6'd20, "R7",
          {24'h0, gpr_wr_thread, gpr_wr_idx}, {24'h0, 2'd1, 6'd20});
      chk(gpr_wr_data === 32'hCAFEF00D, "R7", gpr_wr_data, 32'hCAFEF00D);
      @(negedge clk);
      chk(gpr_wr_en === 1'b0, "R7", {31'h0, gpr_wr_en}, 0);
      chk(gpr[1][20] === 32'hCAFEF00D, "R7", gpr[1][20], 32'hCAFEF00D);
   endtask

   task automatic t_byte();
      issue(0, e_byte(1, 8'hF0, 8'hAB, 10));
      // R8
      chk_cfg(0, 10, 32'h1234A678, "R8");
      issue(0, e_byte(3, 8'hFF, 8'h00, 10));
      chk_cfg(0, 10, 32'h0034A678, "R8");
   endtask

   task automatic t_byte_noclear();
      issue(0, e_byte(0, 8'h0F, 8'h03, 40));
      // R9: byte update to the reset-enable index clears nothing
      chk_cfg(0, 40, 32'h3, "R9"); chk_cfg(0, 10, 32'h0034A678, "R9");
      chk_cfg(0, 21, 32'hA0A0_0001, "R9");
   endtask

   task automatic t_clear();
      gpr[0][13] = 32'h77;
      issue(0, e_wr(13, 0, 40));
      // R9
      chk_cfg(0, 40, 0, "R9"); chk_cfg(0, 10, 0, "R9"); chk_cfg(0, 21, 0, "R9");
      chk_cfg(0, 50, 32'h0BADBEEF, "R9"); chk_cfg(0, 52, 32'h005A0000, "R9");
      chk_cfg(1, 10, 32'hCAFEF00D, "R9");
   endtask

   task automatic t_other();
      // R11
      @(negedge clk);
      vld[2] = 1'b1; wbus[64 +: 32] = 32'h45B0_0A32; #1;
      chk(rdy[2] === 1'b1, "R11", {31'h0, rdy[2]}, 1);
      @(negedge clk);
      wbus[64 +: 32] = 32'hB7FF_0032; #1;
      chk(rdy[2] === 1'b1, "R11", {31'h0, rdy[2]}, 1);
      @(negedge clk);
      vld[2] = 1'b0;
      chk_cfg(0, 50, 32'h0BADBEEF, "R11"); chk_cfg(1, 50, 32'h0BADBEEF, "R11");
      chk_pvt(2, 3, 16'h3333, "R11");
      chk(gpr_wr_en === 1'b0, "R11", {31'h0, gpr_wr_en}, 0);
   endtask

   task automatic t_rr();
      issue(1, e_rd(30, 50));   // last served is thread 1
      @(negedge clk);
      mon_on = 1;
      fork
         issue(0, e_rd(31, 50));
         issue(1, e_rd(32, 50));
         issue(2, e_rd(33, 50));
      join
      repeat (3) @(negedge clk);
      mon_on = 0;
      // R10: one per cycle, order 2,0,1
      chk(nseq == 3, "R10", 32'(nseq), 3);
      chk(seq[0] == 2 && seq[1] == 0 && seq[2] == 1, "R10",
          32'(seq[0]*100 + seq[1]*10 + seq[2]), 32'd201);
   endtask

   initial begin
      for (int t = 0; t < 4; t++) for (int r = 0; r < 64; r++) gpr[t][r] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_reset();
      t_set16();
      t_wr32();
      t_bank_sel();
      t_wr128();
      t_global();
      t_rdcfg();
      t_byte();
      t_byte_noclear();
      t_clear();
      t_other();
      t_rr();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R10 watchdog act=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule